// File: doc/BRIEF.md
# Interrupt Request Flag Controller

This block collects single-cycle event strobes from the surrounding reader front end and latches them into seven sticky interrupt flags: transmit done, receive done, command idle, FIFO high alert, FIFO low alert, error and timer. The flags stay set until software clears them.

Software reaches the block over a simple register bus with a combinational read port. The flag register is changed with a masked write. The top data bit chooses whether the marked flags are set or cleared, and unmarked flags keep their value. A pin configuration register picks push-pull or open-drain drive for the interrupt pad. It also gates two requests that arrive from outside: external-input active and CRC done. A flag enable register selects which latched flags reach the pad.

The pad is active low in both drive modes. In push-pull mode the block always drives the pad and puts the inverted request on it. In open-drain mode the output value is held at 0, and the drive enable rises only while a request is pending.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag register (address 0x04) reads 0x14, which means idle (bit 4) and low alert (bit 2) are set. The pin configuration (0x03) and flag enable (0x02) registers read 0x00, and the pad is released: irqOe = 0 and irqOut = 0.
- R2: A write to 0x04 with data bit 7 = 1 sets every flag whose data bit (6..0) is 1 and leaves the other flags unchanged. The flag bits are tx = 6, rx = 5, idle = 4, hiAlert = 3, loAlert = 2, err = 1, timer = 0.
- R3: A write to 0x04 with data bit 7 = 0 clears every flag whose data bit is 1 and leaves the other flags unchanged.
- R4: A latched flag is never cleared by hardware. The hiAlert flag is set on a rising edge of the FIFO high-alert level and stays set after that level falls.
- R5: A one-cycle strobe on txDone, loAlertEvt, errEvt or timerEvt sets flag bit 6, 2, 1 or 0 respectively on the next clock edge.
- R6: A strobe on rxEnd sets flag bit 5 when rxNoErrMode = 0. When rxNoErrMode = 1, it sets bit 5 only if fifoHasData = 1 in the same cycle.
- R7: A strobe on cmdToIdle sets flag bit 4 when cmdByHost = 0, and does nothing when cmdByHost = 1. A strobe on cmdUnknown always sets bit 4.
- R8: When an event strobe arrives in the same cycle as a software clear of the same flag, the flag ends up set.
- R9: Reads return the flags in bits 6..0 of 0x04 with bit 7 = 0. Address 0x03 returns only bit 7 (push-pull), bit 4 (external enable) and bit 2 (CRC enable), with all other bits 0. Address 0x02 returns the flag enables in bits 6..0 with bit 7 = 0. Any other address returns 0.
- R10: The request is active when any flag is set together with its enable bit in 0x02, when extActReq = 1 with 0x03 bit 4 set, or when crcReq = 1 with 0x03 bit 2 set.
- R11: With 0x03 bit 7 = 1 (push-pull), irqOe = 1 and irqOut is the inverse of the request. With bit 7 = 0 (open-drain), irqOut = 0 and irqOe equals the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register address for reads and writes |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| txDone | input | 1 | Last transmit bit has left the shifter |
| rxEnd | input | 1 | Receiver saw the end of a valid stream |
| rxNoErrMode | input | 1 | Receive flag requires FIFO data |
| fifoHasData | input | 1 | FIFO holds at least one byte |
| cmdToIdle | input | 1 | Command register returned to idle |
| cmdByHost | input | 1 | Qualifies cmdToIdle as a host-written idle |
| cmdUnknown | input | 1 | Unknown command code was written |
| hiAlertLvl | input | 1 | FIFO high-alert status level |
| loAlertEvt | input | 1 | FIFO low-alert event |
| errEvt | input | 1 | Error event |
| timerEvt | input | 1 | Timer event |
| extActReq | input | 1 | External-input active request |
| crcReq | input | 1 | CRC done request |
| irqOut | output | 1 | Pad output value (active low) |
| irqOe | output | 1 | Pad drive enable |

## Verification
The hardest case to reach from the ports is a software clear and an event strobe for the same flag landing on the same clock edge. The stimulus first sets the timer flag. It then raises the bus write that clears bit 0 and the timer strobe on the same falling edge, so both are sampled at one rising edge. The receive and idle qualifiers are covered by holding the qualifying level before the strobe, once in each state. Each time the read of 0x04 shows whether the flag appeared.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int unsigned NUM_FLAGS = 7;
  localparam int unsigned DATA_W    = 8;

  // flag bit positions
  localparam int unsigned B_TX   = 6;
  localparam int unsigned B_RX   = 5;
  localparam int unsigned B_IDLE = 4;
  localparam int unsigned B_HI   = 3;
  localparam int unsigned B_LO   = 2;
  localparam int unsigned B_ERR  = 1;
  localparam int unsigned B_TIM  = 0;

  // pin configuration bit positions
  localparam int unsigned C_PP  = 7;
  localparam int unsigned C_EXT = 4;
  localparam int unsigned C_CRC = 2;

  // control-to-datapath strobes
  typedef struct packed {
    logic                  wrFlags;
    logic                  wrCfg;
    logic                  wrFlagEn;
    logic                  rdFlags;
    logic                  rdCfg;
    logic                  rdFlagEn;
    logic [DATA_W-1:0]     wrData;
    logic [NUM_FLAGS-1:0]  evtSet;
  } irqf_ctl_t;
endpackage

// File: rtl/irqf_ctrl.sv
module irqf_ctrl
  import irqf_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h04,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 'h03,
  parameter logic [ADDR_W-1:0] FEN_ADDR  = 'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              txDone,
  input  logic              rxEnd,
  input  logic              rxNoErrMode,
  input  logic              fifoHasData,
  input  logic              cmdToIdle,
  input  logic              cmdByHost,
  input  logic              cmdUnknown,
  input  logic              hiAlertLvl,
  input  logic              loAlertEvt,
  input  logic              errEvt,
  input  logic              timerEvt,
  output irqf_ctl_t         ctl
);
  logic hiPrev;
  logic hiRise;
  logic rxQual;
  logic idleQual;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hiPrev <= 1'b0;
    else       hiPrev <= hiAlertLvl;
  end

  assign hiRise   = hiAlertLvl & ~hiPrev;
  assign rxQual   = rxEnd & (~rxNoErrMode | fifoHasData);
  assign idleQual = (cmdToIdle & ~cmdByHost) | cmdUnknown;

  always_comb begin
    ctl          = '0;
    ctl.wrData   = busWrData;
    ctl.wrFlags  = busWrEn && (busAddr == FLAG_ADDR);
    ctl.wrCfg    = busWrEn && (busAddr == CFG_ADDR);
    ctl.wrFlagEn = busWrEn && (busAddr == FEN_ADDR);
    ctl.rdFlags  = (busAddr == FLAG_ADDR);
    ctl.rdCfg    = (busAddr == CFG_ADDR);
    ctl.rdFlagEn = (busAddr == FEN_ADDR);
    ctl.evtSet[B_TX]   = txDone;
    ctl.evtSet[B_RX]   = rxQual;
    ctl.evtSet[B_IDLE] = idleQual;
    ctl.evtSet[B_HI]   = hiRise;
    ctl.evtSet[B_LO]   = loAlertEvt;
    ctl.evtSet[B_ERR]  = errEvt;
    ctl.evtSet[B_TIM]  = timerEvt;
  end

  // R6: receive strobe is suppressed without FIFO data in no-error mode
  a_r6_rx_gate: assert property (@(posedge clk) disable iff (!rstN)
    (rxNoErrMode && !fifoHasData) |-> !ctl.evtSet[B_RX]);
  // R7: a host-written idle alone does not raise the idle event
  a_r7_host_idle: assert property (@(posedge clk) disable iff (!rstN)
    (cmdByHost && !cmdUnknown) |-> !ctl.evtSet[B_IDLE]);
  // R4: a held high-alert level raises the event at most once
  a_r4_hi_edge: assert property (@(posedge clk) disable iff (!rstN)
    (hiAlertLvl && $past(hiAlertLvl)) |-> !ctl.evtSet[B_HI]);
endmodule

// File: rtl/irqf_datapath.sv
module irqf_datapath
  import irqf_pkg::*;
#(
  parameter logic [NUM_FLAGS-1:0] RST_FLAGS = 7'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqf_ctl_t         ctl,
  input  logic              extActReq,
  input  logic              crcReq,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut,
  output logic              irqOe
);
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] flagsNext;
  logic [NUM_FLAGS-1:0] flagEn;
  logic                 pushPull;
  logic                 extEn;
  logic                 crcEn;
  logic                 setSel;
  logic                 reqActive;

  assign setSel = ctl.wrData[DATA_W-1];

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_comb begin
      flagsNext[i] = flags[i];
      if (ctl.wrFlags && ctl.wrData[i]) flagsNext[i] = setSel;
      if (ctl.evtSet[i]) flagsNext[i] = 1'b1;  // event wins
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= RST_FLAGS;
    else       flags <= flagsNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pushPull <= 1'b0;
      extEn    <= 1'b0;
      crcEn    <= 1'b0;
      flagEn   <= '0;
    end else begin
      if (ctl.wrCfg) begin
        pushPull <= ctl.wrData[C_PP];
        extEn    <= ctl.wrData[C_EXT];
        crcEn    <= ctl.wrData[C_CRC];
      end
      if (ctl.wrFlagEn) flagEn <= ctl.wrData[NUM_FLAGS-1:0];
    end
  end

  always_comb begin
    busRdData = '0;
    if (ctl.rdFlags) begin
      busRdData[NUM_FLAGS-1:0] = flags;
    end else if (ctl.rdCfg) begin
      busRdData[C_PP]  = pushPull;
      busRdData[C_EXT] = extEn;
      busRdData[C_CRC] = crcEn;
    end else if (ctl.rdFlagEn) begin
      busRdData[NUM_FLAGS-1:0] = flagEn;
    end
  end

  assign reqActive = (|(flags & flagEn)) | (extActReq & extEn) | (crcReq & crcEn);

  always_comb begin
    if (pushPull) begin
      irqOe  = 1'b1;
      irqOut = ~reqActive;
    end else begin
      irqOe  = reqActive;
      irqOut = 1'b0;
    end
  end

  // R8: every strobed flag is set after the edge, whatever the bus did
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|ctl.evtSet) |=> ((flags & $past(ctl.evtSet)) == $past(ctl.evtSet)));
  // R4: without a flag write no set flag is lost
  a_r4_no_autoclear: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrFlags |=> ((flags & $past(flags)) == $past(flags)));
  // R2: a set-write leaves all marked flags set
  a_r2_set_marked: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrFlags && ctl.wrData[DATA_W-1]) |=>
      ((flags & $past(ctl.wrData[NUM_FLAGS-1:0])) == $past(ctl.wrData[NUM_FLAGS-1:0])));
  // R3: a clear-write empties marked flags that had no event
  a_r3_clear_marked: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrFlags && !ctl.wrData[DATA_W-1]) |=>
      ((flags & $past(ctl.wrData[NUM_FLAGS-1:0]) & ~$past(ctl.evtSet)) == '0));
  // R11: open-drain mode never drives a high level
  a_r11_open_drain: assert property (@(posedge clk) disable iff (!rstN)
    (!pushPull) |-> (irqOut == 1'b0));
  // R11: push-pull mode always drives
  a_r11_push_pull: assert property (@(posedge clk) disable iff (!rstN)
    pushPull |-> irqOe);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqf_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h04,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 'h03,
  parameter logic [ADDR_W-1:0] FEN_ADDR  = 'h02,
  parameter logic [6:0] RST_FLAGS = 7'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              txDone,
  input  logic              rxEnd,
  input  logic              rxNoErrMode,
  input  logic              fifoHasData,
  input  logic              cmdToIdle,
  input  logic              cmdByHost,
  input  logic              cmdUnknown,
  input  logic              hiAlertLvl,
  input  logic              loAlertEvt,
  input  logic              errEvt,
  input  logic              timerEvt,
  input  logic              extActReq,
  input  logic              crcReq,
  output logic              irqOut,
  output logic              irqOe
);
  irqf_ctl_t ctl;

  irqf_ctrl #(
    .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .CFG_ADDR(CFG_ADDR), .FEN_ADDR(FEN_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .txDone(txDone), .rxEnd(rxEnd), .rxNoErrMode(rxNoErrMode), .fifoHasData(fifoHasData),
    .cmdToIdle(cmdToIdle), .cmdByHost(cmdByHost), .cmdUnknown(cmdUnknown),
    .hiAlertLvl(hiAlertLvl), .loAlertEvt(loAlertEvt), .errEvt(errEvt), .timerEvt(timerEvt),
    .ctl(ctl)
  );

  irqf_datapath #(.RST_FLAGS(RST_FLAGS)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .extActReq(extActReq), .crcReq(crcReq),
    .busRdData(busRdData), .irqOut(irqOut), .irqOe(irqOe)
  );
endmodule

// File: tb/irq_flag_ctrl_tb_top.sv
module irq_flag_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic txDone = 0, rxEnd = 0, rxNoErrMode = 0, fifoHasData = 0;
  logic cmdToIdle = 0, cmdByHost = 0, cmdUnknown = 0, hiAlertLvl = 0;
  logic loAlertEvt = 0, errEvt = 0, timerEvt = 0, extActReq = 0, crcReq = 0;
  logic irqOut, irqOe;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  typedef struct {
    bit        isPin;
    logic [7:0] exp;
    string     tag;
  } item_t;
  item_t sbq[$];
  event sampleEv;

  always #5 clk = ~clk;

  irq_flag_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .txDone(txDone), .rxEnd(rxEnd), .rxNoErrMode(rxNoErrMode),
    .fifoHasData(fifoHasData), .cmdToIdle(cmdToIdle), .cmdByHost(cmdByHost),
    .cmdUnknown(cmdUnknown), .hiAlertLvl(hiAlertLvl), .loAlertEvt(loAlertEvt),
    .errEvt(errEvt), .timerEvt(timerEvt), .extActReq(extActReq), .crcReq(crcReq),
    .irqOut(irqOut), .irqOe(irqOe)
  );

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(sampleEv);
      #1;
      while (sbq.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sbq.pop_front();
        act = it.isPin ? {6'b0, irqOe, irqOut} : busRdData;
        nCmp++;
        if (act !== it.exp) begin
          nBad++;
          $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  // m[6] tx, m[5] rx, m[4] toIdle, m[3] unknown, m[2] lo, m[1] err, m[0] timer
  task automatic pulse(input logic [6:0] m);
    @(negedge clk);
    txDone = m[6]; rxEnd = m[5]; cmdToIdle = m[4]; cmdUnknown = m[3];
    loAlertEvt = m[2]; errEvt = m[1]; timerEvt = m[0];
    @(negedge clk);
    {txDone, rxEnd, cmdToIdle, cmdUnknown, loAlertEvt, errEvt, timerEvt} = '0;
  endtask

  task automatic expectRead(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    busAddr = a;
    #1;
    it.isPin = 1'b0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    -> sampleEv;
    #2;
  endtask

  // expected {irqOe, irqOut}
  task automatic expectPin(input logic [1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    #1;
    it.isPin = 1'b1; it.exp = {6'b0, e}; it.tag = tag;
    sbq.push_back(it);
    -> sampleEv;
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expectRead(8'h04, 8'h14, "R1 flags reset");
    expectRead(8'h03, 8'h00, "R1 cfg reset");
    expectRead(8'h02, 8'h00, "R1 flag enable reset");
    expectPin(2'b00, "R1 pad released");

    busWrite(8'h04, 8'h7F);
    expectRead(8'h04, 8'h00, "R3 clear all");
    busWrite(8'h04, 8'hC1);
    expectRead(8'h04, 8'h41, "R2 set tx timer");
    busWrite(8'h04, 8'h88);
    expectRead(8'h04, 8'h49, "R2 set hi keeps others");
    busWrite(8'h04, 8'h01);
    expectRead(8'h04, 8'h48, "R3 clear timer only");
    busWrite(8'h04, 8'h7F);

    pulse(7'b1000000);
    expectRead(8'h04, 8'h40, "R5 tx strobe");
    pulse(7'b0000111);
    expectRead(8'h04, 8'h47, "R5 lo err timer strobes");
    busWrite(8'h04, 8'h7F);

    rxNoErrMode = 0; fifoHasData = 0;
    pulse(7'b0100000);
    expectRead(8'h04, 8'h20, "R6 rx plain mode");
    busWrite(8'h04, 8'h7F);
    rxNoErrMode = 1;
    pulse(7'b0100000);
    expectRead(8'h04, 8'h00, "R6 rx no data suppressed");
    fifoHasData = 1;
    pulse(7'b0100000);
    expectRead(8'h04, 8'h20, "R6 rx with data");
    busWrite(8'h04, 8'h7F);
    rxNoErrMode = 0; fifoHasData = 0;

    cmdByHost = 1;
    pulse(7'b0010000);
    expectRead(8'h04, 8'h00, "R7 host idle ignored");
    cmdByHost = 0;
    pulse(7'b0010000);
    expectRead(8'h04, 8'h10, "R7 self idle");
    busWrite(8'h04, 8'h7F);
    pulse(7'b0001000);
    expectRead(8'h04, 8'h10, "R7 unknown command");
    busWrite(8'h04, 8'h7F);

    @(negedge clk); hiAlertLvl = 1;
    expectRead(8'h04, 8'h08, "R4 hi alert rise");
    @(negedge clk); hiAlertLvl = 0;
    repeat (5) @(negedge clk);
    expectRead(8'h04, 8'h08, "R4 hi alert sticky");
    busWrite(8'h04, 8'h7F);
    expectRead(8'h04, 8'h00, "R4 hi alert cleared by software");

    busWrite(8'h04, 8'h81);
    @(negedge clk);
    busAddr = 8'h04; busWrData = 8'h01; busWrEn = 1; timerEvt = 1;
    @(negedge clk);
    busWrEn = 0; timerEvt = 0;
    expectRead(8'h04, 8'h01, "R8 event beats clear");
    busWrite(8'h04, 8'h7F);

    busWrite(8'h03, 8'hFF);
    expectRead(8'h03, 8'h94, "R9 cfg implemented bits");
    busWrite(8'h02, 8'hFF);
    expectRead(8'h02, 8'h7F, "R9 flag enable bit7 zero");
    busWrite(8'h04, 8'hFF);
    expectRead(8'h04, 8'h7F, "R9 flags bit7 zero");
    expectRead(8'h05, 8'h00, "R9 unmapped address");

    expectPin(2'b10, "R11 push-pull active");
    busWrite(8'h03, 8'h00);
    expectPin(2'b10, "R11 open-drain active");
    busWrite(8'h04, 8'h7F);
    expectPin(2'b00, "R10 open-drain idle");
    busWrite(8'h03, 8'h80);
    expectPin(2'b11, "R11 push-pull idle");
    @(negedge clk); extActReq = 1;
    expectPin(2'b11, "R10 ext request not enabled");
    busWrite(8'h03, 8'h90);
    expectPin(2'b10, "R10 ext request enabled");
    @(negedge clk); extActReq = 0;
    expectPin(2'b11, "R10 ext request dropped");
    @(negedge clk); crcReq = 1;
    busWrite(8'h03, 8'h84);
    expectPin(2'b10, "R10 crc request enabled");
    @(negedge clk); crcReq = 0;
    busWrite(8'h04, 8'hC0);
    expectPin(2'b10, "R10 tx flag enabled");
    busWrite(8'h02, 8'h3F);
    expectPin(2'b11, "R10 tx flag masked");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule